// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Block

This block is the register face of a multi-channel DMA controller. A simple 32-bit bus reaches a 4 KB window through a word address. The window holds four groups of registers:

- a global configuration word and a sync word;
- five 32-bit registers for each channel: source, destination, link pointer, control and configuration;
- interrupt status and clear words;
- a read-only row of identification bytes.

The channel count is a parameter, either 8 or 2.

A separate transfer engine reads the stored channel and global registers from output ports. When a channel finishes or faults, the engine sends one-cycle set pulses for terminal count or error. The block holds those raw bits. It masks them with enable bits kept inside each channel's configuration word, and drives registered error, terminal-count and combined interrupt lines. Software reads raw and masked views, and clears raw bits by writing ones.

Top module: `dma_regif`

## Requirements
- R1: After reset, every stored register, raw interrupt bit and interrupt output is zero.
- R2: Global word offsets: 0 reads masked TC OR masked error, 1 reads masked TC, 3 reads masked error, 5 reads raw TC, 6 reads raw error. Offset 12 is the read/write global configuration word and 13 is the read/write sync word. Bit c of each status word belongs to channel c.
- R3: Word offsets 64 to 127 form the channel window. The channel index is word-offset bits [5:3] and the field is bits [2:0], where 0 is source, 1 is destination, 2 is link pointer, 3 is control and 4 is configuration. Each field is a 32-bit read/write register.
- R4: Word offsets 1016 to 1023 read one byte each, zero-extended, in this order: 0x80 with 8 channels or 0x81 with 2 channels, then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. Writes to these offsets have no effect.
- R5: A channel's TC mask bit is bit 15 of its configuration field, and its error mask bit is bit 14.
- R6: A write to word 2 clears each raw TC bit whose data bit is one. A write to word 4 does the same for raw error bits. Words 2 and 4 read zero.
- R7: A set pulse for a channel wins over a clear of the same bit in the same cycle.
- R8: irqTc and irqErr each go high one cycle after any masked TC or error bit, respectively, is set. irqAny is their OR, with the same one-cycle lag.
- R9: Word 7 reads a bitmap holding bit 0 of each channel's configuration field.
- R10: Reads of unlisted offsets, of channel fields 5 to 7, or of a channel index at or above the channel count return zero, and writes to them change nothing.
- R11: The stored channel fields, global configuration and sync words appear unchanged on the output ports, with channel c in bits [32c+31:32c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWordAddr | input | 10 | Word address in the 4 KB window (byte offset / 4) |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regWordAddr, combinational |
| tcSetPulse | input | NumChan | Per-channel terminal-count set pulse |
| errSetPulse | input | NumChan | Per-channel error set pulse |
| chSrcAddr | output | 32*NumChan | Source address of every channel |
| chDstAddr | output | 32*NumChan | Destination address of every channel |
| chLinkPtr | output | 32*NumChan | Link pointer of every channel |
| chCtrl | output | 32*NumChan | Control word of every channel |
| chCfg | output | 32*NumChan | Configuration word of every channel |
| globalCfg | output | 32 | Global configuration word |
| syncCfg | output | 32 | Sync word |
| irqAny | output | 1 | Combined interrupt |
| irqErr | output | 1 | Error interrupt |
| irqTc | output | 1 | Terminal-count interrupt |

## Verification
The main instance has two channels. Channel indices 2 to 7 are then out of range, so a full sweep of all 1024 word offsets covers live registers, dead channels, unused fields and unmapped space. A second instance with eight channels shares the same bus and checks the other identification byte and the top channel slot. A small model in the bench drives set pulses, ones-to-clear writes and mask changes, including a set and a clear in the same cycle. It samples the interrupt lines on both sides of their one-cycle lag.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

  localparam int unsigned DataW     = 32;
  localparam int unsigned WordAddrW = 10;
  localparam int unsigned ChIdxW    = 3;
  localparam int unsigned FldW      = 3;
  localparam int unsigned NumFld    = 5;
  localparam int unsigned TcMaskBit = 15;
  localparam int unsigned ErMaskBit = 14;
  localparam int unsigned EnableBit = 0;

  // global word offsets
  localparam logic [5:0] GwMStat = 6'd0;
  localparam logic [5:0] GwMTc   = 6'd1;
  localparam logic [5:0] GwTcClr = 6'd2;
  localparam logic [5:0] GwMErr  = 6'd3;
  localparam logic [5:0] GwErClr = 6'd4;
  localparam logic [5:0] GwRTc   = 6'd5;
  localparam logic [5:0] GwRErr  = 6'd6;
  localparam logic [5:0] GwEnab  = 6'd7;
  localparam logic [5:0] GwGCfg  = 6'd12;
  localparam logic [5:0] GwSync  = 6'd13;

  typedef enum logic [3:0] {
    RS_NONE, RS_MSTAT, RS_MTC, RS_MERR, RS_RTC, RS_RERR,
    RS_ENAB, RS_GCFG, RS_SYNC, RS_CHAN, RS_ID
  } rd_sel_e;

  typedef struct packed {
    logic              chanWr;
    logic              tcClr;
    logic              errClr;
    logic              gCfgWr;
    logic              syncWr;
    rd_sel_e           rdSel;
    logic [ChIdxW-1:0] chIdx;
    logic [FldW-1:0]   fld;
  } strobe_t;

  function automatic logic [7:0] idByte(int unsigned numChan, logic [2:0] k);
    case (k)
      3'd0: idByte = (numChan == 8) ? 8'h80 : 8'h81;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h0A;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dma_regif_ctrl.sv
module dma_regif_ctrl
  import dma_regif_pkg::*;
#(
  parameter int unsigned NumChan = 8
) (
  input  logic [WordAddrW-1:0] wordAddr,
  input  logic                 wrEn,
  output strobe_t              stb
);

  localparam logic [3:0] ChanWinHi = 4'h1;
  localparam logic [6:0] IdWinHi   = 7'h7F;

  always_comb begin
    stb        = '0;
    stb.rdSel  = RS_NONE;
    stb.chIdx  = wordAddr[5:3];
    stb.fld    = wordAddr[2:0];
    if (wordAddr[9:6] == ChanWinHi) begin
      // R3 / R10: only existing channels and fields 0..4 decode
      if (int'(wordAddr[5:3]) < int'(NumChan) && wordAddr[2:0] < FldW'(NumFld)) begin
        stb.rdSel  = RS_CHAN;
        stb.chanWr = wrEn;
      end
    end else if (wordAddr[9:3] == IdWinHi) begin
      stb.rdSel = RS_ID;
    end else if (wordAddr[9:6] == 4'h0) begin
      case (wordAddr[5:0])
        GwMStat: stb.rdSel = RS_MSTAT;
        GwMTc:   stb.rdSel = RS_MTC;
        GwTcClr: stb.tcClr = wrEn;
        GwMErr:  stb.rdSel = RS_MERR;
        GwErClr: stb.errClr = wrEn;
        GwRTc:   stb.rdSel = RS_RTC;
        GwRErr:  stb.rdSel = RS_RERR;
        GwEnab:  stb.rdSel = RS_ENAB;
        GwGCfg: begin
          stb.rdSel  = RS_GCFG;
          stb.gCfgWr = wrEn;
        end
        GwSync: begin
          stb.rdSel  = RS_SYNC;
          stb.syncWr = wrEn;
        end
        default: stb.rdSel = RS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dma_regif_irq.sv
module dma_regif_irq
  import dma_regif_pkg::*;
#(
  parameter int unsigned NumChan = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tcClr,
  input  logic               errClr,
  input  logic [NumChan-1:0] clrBits,
  input  logic [NumChan-1:0] tcSet,
  input  logic [NumChan-1:0] errSet,
  input  logic [NumChan-1:0] tcMask,
  input  logic [NumChan-1:0] errMask,
  output logic [NumChan-1:0] rawTc,
  output logic [NumChan-1:0] rawErr,
  output logic               irqTc,
  output logic               irqErr,
  output logic               irqAny
);

  logic [NumChan-1:0] tcKeep;
  logic [NumChan-1:0] errKeep;
  logic               tcLevel;
  logic               errLevel;

  assign tcKeep   = tcClr  ? ~clrBits : '1;
  assign errKeep  = errClr ? ~clrBits : '1;
  assign tcLevel  = |(rawTc & tcMask);
  assign errLevel = |(rawErr & errMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawTc  <= '0;
      rawErr <= '0;
      irqTc  <= 1'b0;
      irqErr <= 1'b0;
      irqAny <= 1'b0;
    end else begin
      // set applied after clear: the pulse wins
      rawTc  <= (rawTc & tcKeep) | tcSet;
      rawErr <= (rawErr & errKeep) | errSet;
      irqTc  <= tcLevel;
      irqErr <= errLevel;
      irqAny <= tcLevel | errLevel;
    end
  end

endmodule

// File: rtl/dma_regif_dp.sv
module dma_regif_dp
  import dma_regif_pkg::*;
#(
  parameter int unsigned NumChan = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [DataW-1:0]           wrData,
  input  logic [NumChan-1:0]         rawTc,
  input  logic [NumChan-1:0]         rawErr,
  output logic [NumChan-1:0]         tcMask,
  output logic [NumChan-1:0]         errMask,
  output logic [DataW-1:0]           rdData,
  output logic [NumChan*DataW-1:0]   chSrcAddr,
  output logic [NumChan*DataW-1:0]   chDstAddr,
  output logic [NumChan*DataW-1:0]   chLinkPtr,
  output logic [NumChan*DataW-1:0]   chCtrl,
  output logic [NumChan*DataW-1:0]   chCfg,
  output logic [DataW-1:0]           globalCfg,
  output logic [DataW-1:0]           syncCfg
);

  logic [NumChan-1:0][NumFld-1:0][DataW-1:0] chanQ;
  logic [NumChan-1:0]                        enabMap;

  for (genvar c = 0; c < NumChan; c++) begin : g_chan
    logic chSel;
    assign chSel = stb.chanWr && (stb.chIdx == ChIdxW'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanQ[c] <= '0;
      end else if (chSel) begin
        for (int f = 0; f < int'(NumFld); f++) begin
          if (stb.fld == FldW'(f)) chanQ[c][f] <= wrData;
        end
      end
    end

    assign chSrcAddr[c*DataW +: DataW] = chanQ[c][0];
    assign chDstAddr[c*DataW +: DataW] = chanQ[c][1];
    assign chLinkPtr[c*DataW +: DataW] = chanQ[c][2];
    assign chCtrl[c*DataW +: DataW]    = chanQ[c][3];
    assign chCfg[c*DataW +: DataW]     = chanQ[c][4];
    assign tcMask[c]  = chanQ[c][4][TcMaskBit];
    assign errMask[c] = chanQ[c][4][ErMaskBit];
    assign enabMap[c] = chanQ[c][4][EnableBit];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalCfg <= '0;
      syncCfg   <= '0;
    end else begin
      if (stb.gCfgWr) globalCfg <= wrData;
      if (stb.syncWr) syncCfg   <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      RS_MSTAT: rdData = DataW'((rawTc & tcMask) | (rawErr & errMask));
      RS_MTC:   rdData = DataW'(rawTc & tcMask);
      RS_MERR:  rdData = DataW'(rawErr & errMask);
      RS_RTC:   rdData = DataW'(rawTc);
      RS_RERR:  rdData = DataW'(rawErr);
      RS_ENAB:  rdData = DataW'(enabMap);
      RS_GCFG:  rdData = globalCfg;
      RS_SYNC:  rdData = syncCfg;
      RS_ID:    rdData = DataW'(idByte(NumChan, stb.fld));
      RS_CHAN: begin
        for (int c = 0; c < int'(NumChan); c++) begin
          for (int f = 0; f < int'(NumFld); f++) begin
            if (stb.chIdx == ChIdxW'(c) && stb.fld == FldW'(f)) rdData = chanQ[c][f];
          end
        end
      end
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int unsigned NumChan = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WordAddrW-1:0]     regWordAddr,
  input  logic                     regWrEn,
  input  logic [DataW-1:0]         regWrData,
  output logic [DataW-1:0]         regRdData,
  input  logic [NumChan-1:0]       tcSetPulse,
  input  logic [NumChan-1:0]       errSetPulse,
  output logic [NumChan*DataW-1:0] chSrcAddr,
  output logic [NumChan*DataW-1:0] chDstAddr,
  output logic [NumChan*DataW-1:0] chLinkPtr,
  output logic [NumChan*DataW-1:0] chCtrl,
  output logic [NumChan*DataW-1:0] chCfg,
  output logic [DataW-1:0]         globalCfg,
  output logic [DataW-1:0]         syncCfg,
  output logic                     irqAny,
  output logic                     irqErr,
  output logic                     irqTc
);

  strobe_t            stb;
  logic [NumChan-1:0] rawTc;
  logic [NumChan-1:0] rawErr;
  logic [NumChan-1:0] tcMask;
  logic [NumChan-1:0] errMask;

  dma_regif_ctrl #(.NumChan(NumChan)) ctrl_i (
    .wordAddr (regWordAddr),
    .wrEn     (regWrEn),
    .stb      (stb)
  );

  dma_regif_dp #(.NumChan(NumChan)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWrData),
    .rawTc     (rawTc),
    .rawErr    (rawErr),
    .tcMask    (tcMask),
    .errMask   (errMask),
    .rdData    (regRdData),
    .chSrcAddr (chSrcAddr),
    .chDstAddr (chDstAddr),
    .chLinkPtr (chLinkPtr),
    .chCtrl    (chCtrl),
    .chCfg     (chCfg),
    .globalCfg (globalCfg),
    .syncCfg   (syncCfg)
  );

  dma_regif_irq #(.NumChan(NumChan)) irq_i (
    .clk     (clk),
    .rstN    (rstN),
    .tcClr   (stb.tcClr),
    .errClr  (stb.errClr),
    .clrBits (regWrData[NumChan-1:0]),
    .tcSet   (tcSetPulse),
    .errSet  (errSetPulse),
    .tcMask  (tcMask),
    .errMask (errMask),
    .rawTc   (rawTc),
    .rawErr  (rawErr),
    .irqTc   (irqTc),
    .irqErr  (irqErr),
    .irqAny  (irqAny)
  );

endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk #(
  parameter int unsigned NumChan = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [9:0]         regWordAddr,
  input logic               regWrEn,
  input logic [31:0]        regWrData,
  input logic [31:0]        regRdData,
  input logic [NumChan-1:0] tcSetPulse,
  input logic [NumChan-1:0] errSetPulse,
  input logic [NumChan-1:0] rawTc,
  input logic [NumChan-1:0] rawErr,
  input logic [NumChan-1:0] tcMask,
  input logic [NumChan-1:0] errMask,
  input logic               irqTc,
  input logic               irqErr,
  input logic               irqAny
);

  logic tcClrWr;
  logic erClrWr;
  assign tcClrWr = regWrEn && (regWordAddr == 10'd2);
  assign erClrWr = regWrEn && (regWordAddr == 10'd4);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|tcSetPulse) |=> ((rawTc & $past(tcSetPulse)) == $past(tcSetPulse)));

  p_err_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|errSetPulse) |=> ((rawErr & $past(errSetPulse)) == $past(errSetPulse)));

  p_tc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!(|tcSetPulse) && !tcClrWr) |=> (rawTc == $past(rawTc)));

  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!(|errSetPulse) && !erClrWr) |=> (rawErr == $past(rawErr)));

  p_tc_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tcClrWr && !(|tcSetPulse)) |=> ((rawTc & $past(regWrData[NumChan-1:0])) == '0));

  p_irq_tc_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqTc == $past(|(rawTc & tcMask))));

  p_irq_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqErr == $past(|(rawErr & errMask))));

  p_irq_any_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqAny == $past((|(rawTc & tcMask)) || (|(rawErr & errMask)))));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWordAddr inside {[10'd8:10'd11], [10'd14:10'd63], [10'd128:10'd1015]}) |-> (regRdData == '0));

endmodule

bind dma_regif dma_regif_chk #(.NumChan(NumChan)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .regWordAddr (regWordAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .tcSetPulse  (tcSetPulse),
  .errSetPulse (errSetPulse),
  .rawTc       (rawTc),
  .rawErr      (rawErr),
  .tcMask      (tcMask),
  .errMask     (errMask),
  .irqTc       (irqTc),
  .irqErr      (irqErr),
  .irqAny      (irqAny)
);

// File: tb/dma_regif_tb_top.sv
`timescale 1ns/1ps
module dma_regif_tb_top;

  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [9:0]    regWordAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [NC-1:0] tcSetPulse = '0;
  logic [NC-1:0] errSetPulse = '0;
  logic [31:0]   regRdData, rdData8;
  logic [NC*32-1:0] chSrcAddr, chDstAddr, chLinkPtr, chCtrl, chCfg;
  logic [8*32-1:0]  s8, d8, l8, c8, f8;
  logic [31:0]   globalCfg, syncCfg, g8, y8;
  logic          irqAny, irqErr, irqTc, a8, e8, t8;

  always #2.5 clk = ~clk;

  dma_regif #(.NumChan(NC)) dut_i (
    .clk(clk), .rstN(rstN), .regWordAddr(regWordAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .tcSetPulse(tcSetPulse),
    .errSetPulse(errSetPulse), .chSrcAddr(chSrcAddr), .chDstAddr(chDstAddr),
    .chLinkPtr(chLinkPtr), .chCtrl(chCtrl), .chCfg(chCfg), .globalCfg(globalCfg),
    .syncCfg(syncCfg), .irqAny(irqAny), .irqErr(irqErr), .irqTc(irqTc));

  dma_regif #(.NumChan(8)) dut8_i (
    .clk(clk), .rstN(rstN), .regWordAddr(regWordAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdData8), .tcSetPulse(8'h00),
    .errSetPulse(8'h00), .chSrcAddr(s8), .chDstAddr(d8), .chLinkPtr(l8),
    .chCtrl(c8), .chCfg(f8), .globalCfg(g8), .syncCfg(y8),
    .irqAny(a8), .irqErr(e8), .irqTc(t8));

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // bench model of the two-channel instance
  logic [31:0]   mCh [NC][5];
  logic [31:0]   mG, mS;
  logic [NC-1:0] mTc, mErr;

  function automatic logic [NC-1:0] mTcMask();
    for (int c = 0; c < NC; c++) mTcMask[c] = mCh[c][4][15];
  endfunction
  function automatic logic [NC-1:0] mErMask();
    for (int c = 0; c < NC; c++) mErMask[c] = mCh[c][4][14];
  endfunction

  function automatic logic [31:0] expRd(int w);
    logic [7:0] ids [8];
    ids = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (w >= 1016) return {24'h0, ids[w-1016]};
    if (w >= 64 && w < 128) begin
      if (((w >> 3) & 7) < NC && (w & 7) < 5) return mCh[(w >> 3) & 7][w & 7];
      return 32'h0;
    end
    case (w)
      0:  return 32'((mTc & mTcMask()) | (mErr & mErMask()));
      1:  return 32'(mTc & mTcMask());
      3:  return 32'(mErr & mErMask());
      5:  return 32'(mTc);
      6:  return 32'(mErr);
      7:  begin
            logic [NC-1:0] en;
            for (int c = 0; c < NC; c++) en[c] = mCh[c][4][0];
            return 32'(en);
          end
      12: return mG;
      13: return mS;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(int w);
    if (w >= 1016) return "R4";
    if (w >= 64 && w < 128)
      return (((w >> 3) & 7) < NC && (w & 7) < 5) ? "R3" : "R10";
    if (w == 7) return "R9";
    if (w inside {0, 1, 3, 5, 6, 12, 13}) return "R2";
    return "R10";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic rdChk(int w);
    @(negedge clk);
    regWordAddr = 10'(w);
    regWrEn = 1'b0;
    #1;
    chk(regRdData === expRd(w), reqOf(w), $sformatf("read word %0d", w), regRdData, expRd(w));
  endtask

  // drive one cycle; model updated with clear first, then set (R7)
  task automatic op(bit we, int w, logic [31:0] d, logic [NC-1:0] tp, logic [NC-1:0] ep);
    @(negedge clk);
    regWordAddr = 10'(w); regWrEn = we; regWrData = d;
    tcSetPulse = tp; errSetPulse = ep;
    @(posedge clk);
    #1;
    regWrEn = 1'b0; tcSetPulse = '0; errSetPulse = '0;
    if (we) begin
      if (w >= 64 && w < 128 && ((w >> 3) & 7) < NC && (w & 7) < 5) mCh[(w >> 3) & 7][w & 7] = d;
      if (w == 2)  mTc  = mTc  & ~d[NC-1:0];
      if (w == 4)  mErr = mErr & ~d[NC-1:0];
      if (w == 12) mG = d;
      if (w == 13) mS = d;
    end
    mTc  = mTc | tp;
    mErr = mErr | ep;
  endtask

  task automatic irqChk(string what);
    logic et, ee;
    et = |(mTc & mTcMask());
    ee = |(mErr & mErMask());
    chk(irqTc === et, "R8", {what, " irqTc"}, 32'(irqTc), 32'(et));
    chk(irqErr === ee, "R8", {what, " irqErr"}, 32'(irqErr), 32'(ee));
    chk(irqAny === (et | ee), "R8", {what, " irqAny"}, 32'(irqAny), 32'(et | ee));
  endtask

  // op, then the one-cycle lag of R8, then status reads
  task automatic intOp(string what, bit we, int w, logic [31:0] d, logic [NC-1:0] tp, logic [NC-1:0] ep);
    logic ot, oe;
    ot = |(mTc & mTcMask());
    oe = |(mErr & mErMask());
    op(we, w, d, tp, ep);
    chk(irqTc === ot && irqErr === oe, "R8", {what, " lag"}, {irqTc, irqErr}, {ot, oe});
    @(posedge clk); #1;
    irqChk(what);
    foreach (mTc[i]) begin end
    rdChk(0); rdChk(1); rdChk(3); rdChk(5); rdChk(6);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) for (int f = 0; f < 5; f++) mCh[c][f] = '0;
    mG = '0; mS = '0; mTc = '0; mErr = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state at the ports and through a full read sweep
    chk(chCfg === '0 && chSrcAddr === '0 && globalCfg === '0 && syncCfg === '0, "R1",
        "reset outputs", chCfg[31:0], 32'h0);
    irqChk("R1 reset");
    for (int w = 0; w < 1024; w++) rdChk(w);

    // R3/R10/R4: write every channel slot and every dead offset
    for (int w = 64; w < 128; w++) op(1'b1, w, 32'h9E37_79B9 * w, '0, '0);
    for (int w = 8; w < 12; w++)   op(1'b1, w, 32'hFFFF_FFFF, '0, '0);
    for (int w = 14; w < 64; w++)  op(1'b1, w, 32'hFFFF_FFFF, '0, '0);
    for (int w = 128; w < 1024; w++) op(1'b1, w, 32'hFFFF_FFFF, '0, '0);
    op(1'b1, 12, 32'hCAFE_0012, '0, '0);
    op(1'b1, 13, 32'h0BAD_F00D, '0, '0);
    for (int w = 0; w < 1024; w++) rdChk(w);

    // R11: stored values on the output ports
    for (int c = 0; c < NC; c++) begin
      chk(chSrcAddr[c*32 +: 32] === mCh[c][0], "R11", "src port", chSrcAddr[c*32 +: 32], mCh[c][0]);
      chk(chDstAddr[c*32 +: 32] === mCh[c][1], "R11", "dst port", chDstAddr[c*32 +: 32], mCh[c][1]);
      chk(chLinkPtr[c*32 +: 32] === mCh[c][2], "R11", "link port", chLinkPtr[c*32 +: 32], mCh[c][2]);
      chk(chCtrl[c*32 +: 32] === mCh[c][3], "R11", "ctrl port", chCtrl[c*32 +: 32], mCh[c][3]);
      chk(chCfg[c*32 +: 32] === mCh[c][4], "R11", "cfg port", chCfg[c*32 +: 32], mCh[c][4]);
    end
    chk(globalCfg === mG && syncCfg === mS, "R11", "global ports", globalCfg, mG);

    // R5: ch0 both masks and enable, ch1 TC mask only
    op(1'b1, 64 + 4, 32'h0000_C001, '0, '0);
    op(1'b1, 72 + 4, 32'h0000_8000, '0, '0);
    rdChk(7);
    intOp("R5 tc0 err1", 1'b0, 0, 0, 2'b01, 2'b10);
    intOp("R5 err0", 1'b0, 0, 0, 2'b00, 2'b01);
    // R6: clear TC ch0 while ch1 is set
    intOp("R6 clr tc0", 1'b1, 2, 32'h1, 2'b10, 2'b00);
    // R7: clear and set of ch1 in the same cycle
    intOp("R7 set wins", 1'b1, 2, 32'h2, 2'b10, 2'b00);
    intOp("R7 err set wins", 1'b1, 4, 32'h1, 2'b00, 2'b01);
    // R5: drop ch1 TC mask, raw stays
    intOp("R5 unmask", 1'b1, 72 + 4, 32'h0, 2'b00, 2'b00);
    // R6: clear every error bit
    intOp("R6 clr err", 1'b1, 4, 32'hFFFF_FFFF, 2'b00, 2'b00);
    intOp("R6 clr tc", 1'b1, 2, 32'h3, 2'b00, 2'b00);
    rdChk(2); rdChk(4);

    // eight-channel instance: ID byte and top channel slot
    @(negedge clk); regWordAddr = 10'd1016; #1;
    chk(rdData8 === 32'h80, "R4", "8ch id byte", rdData8, 32'h80);
    op(1'b1, 64 + 7*8 + 4, 32'h0000_0001, '0, '0);
    @(negedge clk); regWordAddr = 10'(64 + 7*8 + 4); #1;
    chk(rdData8 === 32'h1, "R3", "8ch ch7 cfg", rdData8, 32'h1);
    chk(regRdData === 32'h0, "R10", "2ch ch7 cfg", regRdData, 32'h0);
    @(negedge clk); regWordAddr = 10'd7; #1;
    chk(rdData8[7] === 1'b1, "R9", "8ch enable bit7", rdData8, 32'h80);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule